// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

A purely combinational unit that inspects one 32-bit binary floating-point operand and reports what kind of value it holds: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. It also produces a quieted copy of the operand and a flag that marks an invalid operation. A floating-point pipeline places it in front of any stage that must pass NaNs on without letting a signaling one through.

One mode input chooses between two conventions for the top fraction bit. In the 2008 convention, a set top bit marks a quiet NaN. In the legacy convention, a set top bit marks a signaling NaN. Quieting flips that bit to its quiet sense. In the legacy convention, quieting must never leave an all-zero fraction, because that would turn the NaN into an infinity. When the fraction would become zero, the next lower fraction bit is set instead.

Top module: `fp32_nan_quiet`

## Requirements
- R1: `class_o` is always one-hot, with bit 0 = zero, bit 1 = subnormal, bit 2 = normal, bit 3 = infinity, bit 4 = quiet NaN and bit 5 = signaling NaN.
- R2: An operand whose exponent field (bits 30:23) is all zeros reports zero when the fraction (bits 22:0) is zero and subnormal otherwise.
- R3: An operand with an exponent field that is neither all zeros nor all ones reports normal. An all-ones exponent with a zero fraction reports infinity.
- R4: An operand with an all-ones exponent and a nonzero fraction reports one of the two NaN classes.
- R5: A NaN is signaling exactly when `nan2008_i` XOR fraction bit 22 equals 1. `is_snan_o` matches class bit 5.
- R6: With `nan2008_i`=1, a signaling NaN is quieted by setting fraction bit 22. All other fraction bits stay unchanged.
- R7: With `nan2008_i`=0, a signaling NaN is quieted by clearing fraction bit 22. If the fraction is then zero, fraction bit 21 is set, so the result stays a NaN.
- R8: `invalid_o` is 1 exactly when the operand is a signaling NaN under the current mode.
- R9: For any operand that is not a signaling NaN, `quiet_o` equals the operand.
- R10: `quiet_o` always carries the operand's sign bit (bit 31) and exponent field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Single-precision operand |
| nan2008_i | input | 1 | 1 = a set fraction bit 22 means quiet; 0 = a set bit 22 means signaling |
| class_o | output | 6 | One-hot class of the operand |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| quiet_o | output | 32 | Operand with any signaling NaN converted to a quiet NaN |
| invalid_o | output | 1 | Invalid-operation flag, raised when a signaling NaN is quieted |

## Verification
The checker assumes that both inputs hold known values whenever it evaluates, so every check is guarded against X or Z on the operand and the mode bit. The bench initializes both inputs at declaration and only ever drives fully defined words. Uniformly random words would almost never hit an all-ones exponent, so the random stimulus forces the exponent to all ones in a large share of vectors. It also forces fraction patterns that are zero or only the top bit, so the NaN, infinity and legacy-fallback cases are reached under both modes.

// File: rtl/fp32_nan_quiet.sv
module fp32_nan_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] operand_i,
  input  logic                  nan2008_i,
  output logic [5:0]            class_o,
  output logic                  is_snan_o,
  output logic [EXP_W+FRAC_W:0] quiet_o,
  output logic                  invalid_o
);
  localparam int QB = FRAC_W - 1;

  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_max, exp_min, frac_nz, is_nan;
  logic [FRAC_W-1:0] frac_legacy, frac_quiet;

  assign sign    = operand_i[EXP_W+FRAC_W];
  assign expo    = operand_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac    = operand_i[FRAC_W-1:0];
  assign exp_max = &expo;
  assign exp_min = ~|expo;
  assign frac_nz = |frac;
  assign is_nan  = exp_max & frac_nz;

  assign is_snan_o = is_nan & (nan2008_i ^ frac[QB]);
  assign invalid_o = is_snan_o;

  assign class_o[0] = exp_min & ~frac_nz;
  assign class_o[1] = exp_min & frac_nz;
  assign class_o[2] = ~exp_min & ~exp_max;
  assign class_o[3] = exp_max & ~frac_nz;
  assign class_o[4] = is_nan & ~is_snan_o;
  assign class_o[5] = is_snan_o;

  always_comb begin
    frac_legacy     = frac;
    frac_legacy[QB] = 1'b0;
    if (frac_legacy == '0) frac_legacy[QB-1] = 1'b1;
  end

  always_comb begin
    frac_quiet = frac;
    if (is_snan_o) begin
      if (nan2008_i) frac_quiet[QB] = 1'b1;
      else           frac_quiet     = frac_legacy;
    end
  end

  assign quiet_o = {sign, expo, frac_quiet};
endmodule

// File: rtl/fp32_nan_quiet_chk.sv
module fp32_nan_quiet_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic [EXP_W+FRAC_W:0] operand_i,
  input logic                  nan2008_i,
  input logic [5:0]            class_o,
  input logic                  is_snan_o,
  input logic [EXP_W+FRAC_W:0] quiet_o,
  input logic                  invalid_o
);
  logic in_nan;
  assign in_nan = (&operand_i[EXP_W+FRAC_W-1:FRAC_W]) & (|operand_i[FRAC_W-1:0]);

  always_comb begin
    if (!$isunknown({operand_i, nan2008_i})) begin
      assert_class_onehot_R1: assert ($onehot(class_o));
      assert_snan_class_R5: assert (is_snan_o == class_o[5]);
      assert_invalid_snan_R8: assert (invalid_o == class_o[5]);
      assert_nan_stays_nan_R7: assert (!in_nan || (|quiet_o[FRAC_W-1:0]));
      assert_passthrough_R9: assert (class_o[5] || quiet_o == operand_i);
      assert_sign_exp_kept_R10: assert (quiet_o[EXP_W+FRAC_W:FRAC_W] == operand_i[EXP_W+FRAC_W:FRAC_W]);
    end
  end
endmodule

bind fp32_nan_quiet fp32_nan_quiet_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .operand_i(operand_i), .nan2008_i(nan2008_i), .class_o(class_o),
  .is_snan_o(is_snan_o), .quiet_o(quiet_o), .invalid_o(invalid_o)
);

// File: tb/tb_fp32_nan_quiet.sv
module tb_fp32_nan_quiet;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op = 32'h0;
  logic        mode = 1'b0;
  logic [5:0]  cls;
  logic        snan, inv;
  logic [31:0] qout;
  int          nvec = 0, nfail = 0, cycles = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  fp32_nan_quiet dut (
    .operand_i(op), .nan2008_i(mode), .class_o(cls),
    .is_snan_o(snan), .quiet_o(qout), .invalid_o(inv)
  );

  function automatic logic [5:0] exp_class(logic [31:0] v, logic m);
    logic [7:0] e = v[30:23];
    logic [22:0] f = v[22:0];
    if (e == 8'h00) return (f == 0) ? 6'b000001 : 6'b000010;
    if (e != 8'hFF) return 6'b000100;
    if (f == 0) return 6'b001000;
    return (m ^ f[22]) ? 6'b100000 : 6'b010000;
  endfunction

  function automatic logic [31:0] exp_quiet(logic [31:0] v, logic m);
    logic [31:0] r = v;
    if (exp_class(v, m) != 6'b100000) return v;
    if (m) r[22] = 1'b1;
    else begin
      r[22] = 1'b0;
      if (r[22:0] == 0) r[21] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    nvec++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s op=%h mode=%0d actual=%h expected=%h", tag, op, mode, act, expv);
    end
  endtask

  task automatic apply(logic [31:0] v, logic m);
    logic [5:0] ec;
    logic [31:0] eq;
    @(negedge clk);
    op = v; mode = m;
    @(posedge clk);
    ec = exp_class(v, m);
    eq = exp_quiet(v, m);
    check("R1", 32'($countones(cls)), 32'd1);
    if (ec[1:0] != 0)      check("R2", 32'(cls), 32'(ec));
    else if (ec[3:2] != 0) check("R3", 32'(cls), 32'(ec));
    else                   check("R4", 32'(cls), 32'(ec));
    check("R5", 32'(snan), 32'(ec[5]));
    check("R8", 32'(inv), 32'(ec[5]));
    if (ec[5] && m)       check("R6", qout, eq);
    else if (ec[5])       check("R7", qout, eq);
    else                  check("R9", qout, v);
    check("R10", 32'(qout[31:23]), 32'(v[31:23]));
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // reset-state operand: +0, class zero (R2)
    check("R2", 32'(cls), 32'b000001);
    // directed corners
    apply(32'h0000_0000, 1'b1);   // R2 zero
    apply(32'h8000_0001, 1'b0);   // R2 subnormal
    apply(32'h3F80_0000, 1'b0);   // R3 normal
    apply(32'hFF80_0000, 1'b1);   // R3 infinity
    apply(32'h7FC0_0000, 1'b1);   // R5 quiet in 2008 mode
    apply(32'h7FC0_0000, 1'b0);   // R7 legacy snan, fallback bit 21
    apply(32'h7F80_0001, 1'b1);   // R6 2008 snan
    apply(32'h7F80_0001, 1'b0);   // R9 legacy quiet passthrough
    apply(32'hFFC0_0005, 1'b0);   // R7 legacy snan, other bits kept
    apply(32'hFFFF_FFFF, 1'b0);   // R7
    apply(32'hFFBF_FFFF, 1'b1);   // R6
    apply(32'h7F7F_FFFF, 1'b1);   // R3 max normal
    for (int i = 0; i < 4000; i++) begin
      v = $urandom();
      case ($urandom_range(0, 5))
        0, 1: v[30:23] = 8'hFF;
        2: begin v[30:23] = 8'hFF; v[21:0] = ($urandom_range(0, 1) != 0) ? 22'h0 : 22'h1; end
        3: v[30:23] = 8'h00;
        default: ;
      endcase
      apply(v, 1'($urandom_range(0, 1)));
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule